// File: doc/BRIEF.md
# ADC Conversion Result Register with Overrun Control

This block holds the result of an analog-to-digital converter between conversion and software read. Each conversion-complete strobe brings a raw sample of up to 12 bits. The block cuts the sample down to the selected resolution (12, 10, 8 or 6 bits) and places it right- or left-justified in a 16-bit data word. It also tracks an end-of-conversion flag and an overrun flag.

A small word-addressed register port reads the data word and the flag word, and clears the flags. The data word sits at address 0. The flag word sits at address 1. A read of the data word consumes the result and drops the end-of-conversion flag.

An overrun happens when a new result arrives before the previous one was consumed. In that case the overrun mode input decides which result is kept: the older unread one, or the newest one. One interrupt output combines the two flags, each gated by its own enable.

Top module: `adc_result_reg`

## Requirements
- R1: After reset, the data word is 0x0000, both flags are 0, and `irq_o` is 0.
- R2: With `align_left_i`=0, the data word holds the low N raw bits in bits N-1:0, with zeros above. N is 12, 10, 8 or 6 for `res_sel_i` codes 0, 1, 2 and 3. Raw bits above N are ignored.
- R3: With `align_left_i`=1, a 12-, 10- or 8-bit result has its MSB at bit 15. A 6-bit result sits in bits 7:2. All other bits are zero.
- R4: On every `conv_done_i`, the end-of-conversion flag sets. If no overrun blocks it, the data word takes the formatted result at that clock edge.
- R5: The overrun flag sets when `conv_done_i` arrives while the end-of-conversion flag is 1 and is not being cleared in that same cycle.
- R6: With `ovr_mode_i`=0, a result that completes while an overrun occurs, or while the overrun flag is still 1, is discarded. The data word keeps its old value.
- R7: With `ovr_mode_i`=1, every completed result is loaded into the data word, even during an overrun.
- R8: The flag word at address 1 reads end-of-conversion in bit 0 and overrun in bit 1, with zeros above. A write to address 1 clears the end-of-conversion flag where bit 0 is 1 and the overrun flag where bit 1 is 1. Zero bits have no effect.
- R9: A read of address 0 returns the current data word in the same cycle and clears the end-of-conversion flag. If a conversion completes in that same cycle, the new result is loaded, the end-of-conversion flag stays 1, and no overrun is flagged.
- R10: `irq_o` is 1 exactly when (end-of-conversion flag AND `eoc_ie_i`) OR (overrun flag AND `ovr_ie_i`).
- R11: A new overrun in the same cycle as a write that clears the overrun flag leaves the overrun flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | Conversion-complete strobe |
| conv_raw_i | input | 12 | Raw sample, right-justified at the selected resolution |
| res_sel_i | input | 2 | Resolution code: 0=12, 1=10, 2=8, 3=6 bits |
| align_left_i | input | 1 | 1 selects left alignment |
| ovr_mode_i | input | 1 | 0 keeps the old data on overrun, 1 overwrites it |
| eoc_ie_i | input | 1 | End-of-conversion interrupt enable |
| ovr_ie_i | input | 1 | Overrun interrupt enable |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word address: 0 data, 1 flags, others read zero |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from the current state |
| irq_o | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle and must resolve correctly: a consuming access (a data read, or a flag-clearing write) and a new conversion completing. The bench forces this in two ways. Directed cycles assert `conv_done_i` together with a data read, and together with an overrun-clearing write. Random stimulus also overlaps them often. A bench model applies the rules in R9 and R11 in a fixed order: a consuming access cancels the overrun condition, and a flag set wins over a flag clear. The data word and the flag word are then read back and compared with that model.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  localparam int NUM_RES = 4;
  localparam int RES_STEP = 2;
  localparam int ST_EOC = 0;
  localparam int ST_OVR = 1;

  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_STAT = 2'd1
  } reg_addr_e;
endpackage

// File: rtl/adc_res_fmt.sv
module adc_res_fmt #(
  parameter int DATA_W = 16,
  parameter int RAW_W  = 12
) (
  input  logic [RAW_W-1:0]  raw_i,
  input  logic [1:0]        res_i,
  input  logic              left_i,
  output logic [DATA_W-1:0] fmt_o
);
  import adc_res_pkg::*;
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] cand [NUM_RES];

  // one candidate per resolution code, selected afterwards
  for (genvar k = 0; k < NUM_RES; k++) begin : g_res
    localparam int RB  = RAW_W - RES_STEP * k;
    localparam int LSH = (RB >= HALF) ? (DATA_W - RB) : (HALF - RB);
    logic [DATA_W-1:0] right_w;
    assign right_w = DATA_W'(raw_i[RB-1:0]);
    assign cand[k] = left_i ? (right_w << LSH) : right_w;
  end

  assign fmt_o = cand[res_i];
endmodule

// File: rtl/adc_res_store.sv
module adc_res_store #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] fmt_i,
  input  logic              ovr_mode_i,
  input  logic              eoc_clr_i,
  input  logic              ovr_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              eoc_o,
  output logic              ovr_o
);
  logic [DATA_W-1:0] data_q;
  logic eoc_q, ovr_q;
  logic ovr_evt, load;

  // a result consumed in this cycle is not an overrun
  assign ovr_evt = conv_done_i & eoc_q & ~eoc_clr_i;
  assign load    = conv_done_i & (ovr_mode_i | ~(ovr_q | ovr_evt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      eoc_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (load) data_q <= fmt_i;
      if (conv_done_i)    eoc_q <= 1'b1;
      else if (eoc_clr_i) eoc_q <= 1'b0;
      if (ovr_evt)        ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign eoc_o  = eoc_q;
  assign ovr_o  = ovr_q;

  p_eoc_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i |=> eoc_q);
  p_ovr_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && eoc_q && !eoc_clr_i) |=> ovr_q);
  p_keep_old_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovr_mode_i && conv_done_i && ovr_q) |=> $stable(data_q));
  p_take_new_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_mode_i && conv_done_i) |=> (data_q == $past(fmt_i)));
  p_no_spurious_ovr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovr_clr_i && !conv_done_i) |=> (ovr_q == $past(ovr_q)));
  p_same_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && eoc_clr_i && !ovr_q) |=> (!ovr_q && data_q == $past(fmt_i)));
endmodule

// File: rtl/adc_res_regif.sv
module adc_res_regif #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              eoc_i,
  input  logic              ovr_i,
  input  logic              eoc_ie_i,
  input  logic              ovr_ie_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              eoc_clr_o,
  output logic              ovr_clr_o,
  output logic              irq_o
);
  import adc_res_pkg::*;
  logic sel_data, sel_stat, rd_data, wr_stat;

  assign sel_data = (addr_i == ADDR_W'(ADDR_DATA));
  assign sel_stat = (addr_i == ADDR_W'(ADDR_STAT));
  assign rd_data  = req_i & ~we_i & sel_data;
  assign wr_stat  = req_i & we_i & sel_stat;

  assign eoc_clr_o = rd_data | (wr_stat & wdata_i[ST_EOC]);
  assign ovr_clr_o = wr_stat & wdata_i[ST_OVR];

  always_comb begin
    rdata_o = '0;
    if (sel_data) rdata_o = data_i;
    else if (sel_stat) begin
      rdata_o[ST_EOC] = eoc_i;
      rdata_o[ST_OVR] = ovr_i;
    end
  end

  assign irq_o = (eoc_i & eoc_ie_i) | (ovr_i & ovr_ie_i);
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int DATA_W = 16,
  parameter int RAW_W  = 12,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [RAW_W-1:0]  conv_raw_i,
  input  logic [1:0]        res_sel_i,
  input  logic              align_left_i,
  input  logic              ovr_mode_i,
  input  logic              eoc_ie_i,
  input  logic              ovr_ie_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] fmt_w, data_w;
  logic eoc_w, ovr_w, eoc_clr_w, ovr_clr_w;

  adc_res_fmt #(.DATA_W(DATA_W), .RAW_W(RAW_W)) u_fmt (
    .raw_i (conv_raw_i),
    .res_i (res_sel_i),
    .left_i(align_left_i),
    .fmt_o (fmt_w)
  );

  adc_res_store #(.DATA_W(DATA_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .conv_done_i(conv_done_i),
    .fmt_i      (fmt_w),
    .ovr_mode_i (ovr_mode_i),
    .eoc_clr_i  (eoc_clr_w),
    .ovr_clr_i  (ovr_clr_w),
    .data_o     (data_w),
    .eoc_o      (eoc_w),
    .ovr_o      (ovr_w)
  );

  adc_res_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .data_i   (data_w),
    .eoc_i    (eoc_w),
    .ovr_i    (ovr_w),
    .eoc_ie_i (eoc_ie_i),
    .ovr_ie_i (ovr_ie_i),
    .rdata_o  (rdata_o),
    .eoc_clr_o(eoc_clr_w),
    .ovr_clr_o(ovr_clr_w),
    .irq_o    (irq_o)
  );

  p_right_high_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!align_left_i && res_sel_i == 2'd3) |-> (fmt_w[DATA_W-1:6] == '0));
  p_left_low_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align_left_i && res_sel_i == 2'd0) |-> (fmt_w[3:0] == '0));
  p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eoc_ie_i && !ovr_ie_i) |-> !irq_o);
  p_ovr_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_w && conv_done_i && eoc_w && !eoc_clr_w) |=> ovr_w);
endmodule

// File: tb/adc_result_reg_tb_top.sv
module adc_result_reg_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic conv_done_i = 1'b0;
  logic [11:0] conv_raw_i = '0;
  logic [1:0] res_sel_i = '0;
  logic align_left_i = 1'b0, ovr_mode_i = 1'b0, eoc_ie_i = 1'b0, ovr_ie_i = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic irq_o;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_data = '0;
  logic m_eoc = 1'b0, m_ovr = 1'b0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  adc_result_reg dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .conv_done_i(conv_done_i), .conv_raw_i(conv_raw_i),
    .res_sel_i(res_sel_i), .align_left_i(align_left_i), .ovr_mode_i(ovr_mode_i),
    .eoc_ie_i(eoc_ie_i), .ovr_ie_i(ovr_ie_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [15:0] exp_fmt(input logic [1:0] res, input logic left,
                                          input logic [11:0] raw);
    int rb = 12 - 2 * int'(res);
    logic [15:0] v = 16'(raw) & 16'((1 << rb) - 1);
    if (left) v = v << ((rb >= 8) ? (16 - rb) : (8 - rb));
    return v;
  endfunction

  function automatic logic [15:0] exp_read(input logic [1:0] a);
    if (a == 2'd0) return m_data;
    if (a == 2'd1) return {14'b0, m_ovr, m_eoc};
    return 16'h0000;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, check read combinationally, update model at posedge
  task automatic cyc(input logic d, input logic [11:0] raw, input logic rq, input logic w,
                     input logic [1:0] a, input logic [15:0] wd, input string tag);
    logic rd, eclr, oclr, evt;
    conv_done_i = d; conv_raw_i = raw; req_i = rq; we_i = w; addr_i = a; wdata_i = wd;
    #1;
    if (rq && !w) check(tag, rdata_o, exp_read(a));
    rd   = rq && !w && a == 2'd0;
    eclr = rd || (rq && w && a == 2'd1 && wd[0]);
    oclr = rq && w && a == 2'd1 && wd[1];
    evt  = d && m_eoc && !eclr;
    @(posedge clk_i);
    if (d && (ovr_mode_i || !(m_ovr || evt))) m_data = exp_fmt(res_sel_i, align_left_i, raw);
    if (d) m_eoc = 1'b1; else if (eclr) m_eoc = 1'b0;
    if (evt) m_ovr = 1'b1; else if (oclr) m_ovr = 1'b0;
    #1;
    check("R10", {15'b0, irq_o}, {15'b0, (m_eoc & eoc_ie_i) | (m_ovr & ovr_ie_i)});
    @(negedge clk_i);
    conv_done_i = 1'b0; req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic conv(input logic [11:0] raw);
    cyc(1'b1, raw, 1'b0, 1'b0, 2'd0, 16'h0, "R4");
  endtask
  task automatic rd(input logic [1:0] a, input string tag);
    cyc(1'b0, 12'h0, 1'b1, 1'b0, a, 16'h0, tag);
  endtask
  task automatic wr_stat(input logic [15:0] wd);
    cyc(1'b0, 12'h0, 1'b1, 1'b1, 2'd1, wd, "R8");
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R1", {15'b0, irq_o}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(2'd0, "R1");
    rd(2'd1, "R1");

    // R2 right alignment per resolution
    for (int r = 0; r < 4; r++) begin
      res_sel_i = 2'(r); align_left_i = 1'b0;
      conv(12'hFFF); rd(2'd0, "R2");
      conv(12'h9C3); rd(2'd0, "R2");
    end
    // R3 left alignment per resolution
    for (int r = 0; r < 4; r++) begin
      res_sel_i = 2'(r); align_left_i = 1'b1;
      conv(12'hA5B); rd(2'd0, "R3");
      conv(12'hFFF); rd(2'd0, "R3");
    end
    res_sel_i = 2'd0; align_left_i = 1'b0;

    // R5/R6 overrun keeping old data
    ovr_mode_i = 1'b0;
    conv(12'h111); conv(12'h222);
    rd(2'd1, "R5");
    rd(2'd0, "R6");
    conv(12'h333); rd(2'd0, "R6");
    wr_stat(16'h0003); rd(2'd1, "R8");

    // R8 writing zeros does nothing
    conv(12'h444); conv(12'h555);
    wr_stat(16'hFFFC); rd(2'd1, "R8");
    wr_stat(16'h0002); rd(2'd1, "R8");
    rd(2'd0, "R8");

    // R7 overwrite mode
    ovr_mode_i = 1'b1;
    conv(12'h666); conv(12'h777); conv(12'h888);
    rd(2'd0, "R7"); rd(2'd1, "R7");
    wr_stat(16'h0003);
    ovr_mode_i = 1'b0;

    // R9 read and conversion in one cycle
    conv(12'hABC);
    cyc(1'b1, 12'hDEF, 1'b1, 1'b0, 2'd0, 16'h0, "R9");
    rd(2'd1, "R9");
    rd(2'd0, "R9");

    // R11 overrun wins over a clearing write
    conv(12'h123);
    cyc(1'b1, 12'h456, 1'b1, 1'b1, 2'd1, 16'h0002, "R11");
    rd(2'd1, "R11");
    wr_stat(16'h0003);

    // R10 interrupt enables
    eoc_ie_i = 1'b1; conv(12'h010); rd(2'd0, "R10");
    eoc_ie_i = 1'b0; ovr_ie_i = 1'b1; conv(12'h020); conv(12'h030);
    wr_stat(16'h0003); ovr_ie_i = 1'b0;

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic d, rq, w;
      logic [1:0] a;
      if ($urandom_range(0, 31) == 0) begin
        res_sel_i = 2'($urandom_range(0, 3));
        align_left_i = 1'($urandom_range(0, 1));
        ovr_mode_i = 1'($urandom_range(0, 1));
        eoc_ie_i = 1'($urandom_range(0, 1));
        ovr_ie_i = 1'($urandom_range(0, 1));
      end
      d  = ($urandom_range(0, 2) == 0);
      rq = ($urandom_range(0, 1) == 0);
      w  = ($urandom_range(0, 3) == 0);
      a  = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(2, 3)) : 2'($urandom_range(0, 1));
      cyc(d, 12'($urandom()), rq, w, a, 16'($urandom()), (a == 2'd0) ? "R4" : "R5");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule